// File: doc/BRIEF.md
# Domain-Based Access Permission Checker

This block decides whether a memory access may go ahead once the translation step has produced a descriptor for it. It takes the kind of access (data read, data write or instruction fetch), the privilege level of the requester, and three fields from the descriptor: the domain number, a 2-bit permission field and an execute-never flag. A 32-bit domain control register, loaded through a simple write port, holds a 2-bit mode for each of sixteen domains.

Checking happens on two levels. First the domain mode is looked up. It can refuse every access, grant every access without looking at the descriptor, or hand the decision to the descriptor. In that last case the execute-never flag and the permission field decide, and unprivileged or write accesses can be barred. The allow or fault verdict is combinational. Each faulting access also raises a one-cycle exception request. The first fault is latched into status outputs: a cause code, the domain and the virtual address. These stay frozen until software clears them.

Top module: `dom_perm_check`

## Requirements
- R1: After reset the domain control register is all zeros, `exc_req` and `fsr_valid` are 0, and every valid access faults with a domain fault.
- R2: With `ctl_we` high, `ctl_wdata` is loaded at the clock edge. Domain n takes its mode from bits [2n+1:2n]. An access in the same cycle as the write is judged with the old value.
- R3: Domain mode 00 (refuse) and 10 (reserved) fault every valid access with cause code 01 (domain fault).
- R4: Domain mode 11 (bypass) allows every valid access, whatever the permission field and the execute-never flag say.
- R5: In domain mode 01 (descriptor decides), an instruction fetch (`acc_kind` 10 or 11) with `desc_xn`=1 faults with cause code 11 (execute-never). This cause wins over a permission fault. Data accesses ignore `desc_xn`.
- R6: In domain mode 01, the permission field decides as follows, with cause code 10 on failure. Field 11 allows any access. Field 10 allows privileged reads and writes, and unprivileged reads only. Field 01 allows privileged accesses only. Field 00 allows nothing. A fetch counts as a read, and `acc_kind` 01 is a write.
- R7: `acc_allow` and `acc_fault` are combinational and never both high. When `acc_valid` is 0, both are 0.
- R8: `exc_req` is high for exactly the cycle after each clock edge at which a valid access faulted, and at no other time.
- R9: At the edge of a fault, with `fsr_valid` clear, the block sets `fsr_valid` and captures the cause, the domain and the address. While `fsr_valid` is set, later faults leave them unchanged.
- R10: `stat_clr` clears `fsr_valid` at the next edge. If a fault happens in that same cycle, that fault is captured instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Domain control register write enable |
| ctl_wdata | input | 32 | Domain control register write data, 2 bits per domain |
| stat_clr | input | 1 | Clears the latched fault status |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 1x instruction fetch |
| acc_priv | input | 1 | 1 when the requester is privileged |
| acc_vaddr | input | 32 | Virtual address of the access |
| desc_dom | input | 4 | Domain named by the descriptor |
| desc_ap | input | 2 | Descriptor permission field |
| desc_xn | input | 1 | Descriptor execute-never flag |
| acc_allow | output | 1 | Access may proceed (combinational) |
| acc_fault | output | 1 | Access is refused (combinational) |
| exc_req | output | 1 | One-cycle exception request |
| fsr_valid | output | 1 | Fault status holds a captured fault |
| fsr_code | output | 2 | Captured cause: 01 domain, 10 permission, 11 execute-never |
| fsr_dom | output | 4 | Captured domain number |
| far_addr | output | 32 | Captured faulting virtual address |

## Verification
The verdict outputs are due in the same cycle as the access. The bench drives each access on a falling edge and samples `acc_allow` and `acc_fault` one nanosecond later, before the next rising edge. `exc_req`, the status fields and the effect of a register write or a clear are due one edge later. They are sampled one nanosecond after that rising edge and compared against a bench model that it updates at the same point. The register write is modelled after the verdict of its own cycle is checked, which shows that a write only takes effect on the following access.

// File: rtl/dom_perm_check.sv
module dom_perm_check #(
  parameter  int AW   = 32,
  parameter  int NDOM = 16,
  localparam int DW   = $clog2(NDOM),
  localparam int CW   = 2 * NDOM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          stat_clr,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic          acc_priv,
  input  logic [AW-1:0] acc_vaddr,
  input  logic [DW-1:0] desc_dom,
  input  logic [1:0]    desc_ap,
  input  logic          desc_xn,
  output logic          acc_allow,
  output logic          acc_fault,
  output logic          exc_req,
  output logic          fsr_valid,
  output logic [1:0]    fsr_code,
  output logic [DW-1:0] fsr_dom,
  output logic [AW-1:0] far_addr
);
  localparam logic [1:0] C_NONE = 2'b00, C_DOM = 2'b01, C_PERM = 2'b10, C_XN = 2'b11;

  logic [CW-1:0] dom_ctl;
  logic [1:0]    dmode, cause;
  logic          is_fetch, is_write, ap_ok;

  assign dmode    = dom_ctl[{desc_dom, 1'b0} +: 2];
  assign is_fetch = acc_kind[1];
  assign is_write = (acc_kind == 2'b01);

  always_comb begin
    case (desc_ap)
      2'b00:   ap_ok = 1'b0;
      2'b01:   ap_ok = acc_priv;
      2'b10:   ap_ok = acc_priv | ~is_write;
      default: ap_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (dmode)
      2'b11:   cause = C_NONE;
      2'b01:   cause = (desc_xn && is_fetch) ? C_XN : (ap_ok ? C_NONE : C_PERM);
      default: cause = C_DOM;
    endcase
  end

  assign acc_fault = acc_valid && (cause != C_NONE);
  assign acc_allow = acc_valid && (cause == C_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dom_ctl   <= '0;
      exc_req   <= 1'b0;
      fsr_valid <= 1'b0;
      fsr_code  <= C_NONE;
      fsr_dom   <= '0;
      far_addr  <= '0;
    end else begin
      if (ctl_we) dom_ctl <= ctl_wdata;
      exc_req <= acc_fault;
      if (stat_clr) fsr_valid <= 1'b0;
      if (acc_fault && (!fsr_valid || stat_clr)) begin
        fsr_valid <= 1'b1;
        fsr_code  <= cause;
        fsr_dom   <= desc_dom;
        far_addr  <= acc_vaddr;
      end
    end
  end

  AST_EXC_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n) acc_fault |=> exc_req); // R8
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) exc_req |-> $past(acc_fault)); // R8
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_valid && !stat_clr) |=> (fsr_valid && $stable(fsr_code) && $stable(fsr_dom) && $stable(far_addr))); // R9
  AST_BYPASS_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dmode == 2'b11) |-> acc_allow); // R4
  AST_REFUSE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dmode[0] == 1'b0) |-> acc_fault); // R3
  AST_DATA_IGNORES_XN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_kind[1] && dmode == 2'b01 && desc_ap == 2'b11) |-> acc_allow); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(acc_allow && acc_fault)); // R7
endmodule

// File: tb/dom_perm_check_tb.sv
module dom_perm_check_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_we = 0, stat_clr = 0, acc_valid = 0, acc_priv = 0, desc_xn = 0;
  logic [31:0] ctl_wdata = 0, acc_vaddr = 0, far_addr;
  logic [1:0]  acc_kind = 0, desc_ap = 0, fsr_code;
  logic [3:0]  desc_dom = 0, fsr_dom;
  logic        acc_allow, acc_fault, exc_req, fsr_valid;

  int errors = 0, checks = 0;
  logic [31:0] mctl = 0, mfar = 0;
  logic        mvalid = 0;
  logic [1:0]  mcode = 0;
  logic [3:0]  mdom = 0;

  always #4 clk = ~clk;

  dom_perm_check dut_i (.clk, .rst_n, .ctl_we, .ctl_wdata, .stat_clr, .acc_valid, .acc_kind,
    .acc_priv, .acc_vaddr, .desc_dom, .desc_ap, .desc_xn, .acc_allow, .acc_fault, .exc_req,
    .fsr_valid, .fsr_code, .fsr_dom, .far_addr);

  function automatic logic [1:0] exp_code(logic [31:0] c, logic [3:0] d, logic [1:0] k,
                                           logic p, logic [1:0] ap, logic xn);
    logic [1:0] m = c[2*d +: 2];
    logic ok;
    if (m == 2'b11) return 2'b00;
    if (m != 2'b01) return 2'b01;
    if (k[1] && xn) return 2'b11;
    case (ap)
      2'b00: ok = 0;
      2'b01: ok = p;
      2'b10: ok = p || (k != 2'b01);
      default: ok = 1;
    endcase
    return ok ? 2'b00 : 2'b10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [31:0] wd, input logic clr, input logic v,
                     input logic [1:0] k, input logic p, input logic [31:0] va,
                     input logic [3:0] d, input logic [1:0] ap, input logic xn);
    logic [1:0] ec;
    string tag;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; stat_clr = clr; acc_valid = v; acc_kind = k;
    acc_priv = p; acc_vaddr = va; desc_dom = d; desc_ap = ap; desc_xn = xn;
    #1;
    ec = exp_code(mctl, d, k, p, ap, xn);
    if (!v) tag = "R7";
    else if (ec == 2'b01) tag = (mctl == 0) ? "R1" : "R3";
    else if (ec == 2'b11) tag = "R5";
    else if (mctl[2*d +: 2] == 2'b11) tag = "R4";
    else tag = "R6";
    chk(tag, {30'd0, acc_allow, acc_fault}, {30'd0, v && ec == 0, v && ec != 0});
    @(posedge clk); #1;
    if (we) mctl = wd;
    if (clr) mvalid = 0;
    if (v && ec != 0 && !mvalid) begin
      mvalid = 1; mcode = ec; mdom = d; mfar = va;
    end
    chk("R8", {31'd0, exc_req}, {31'd0, v && ec != 0});
    tag = clr ? "R10" : "R9";
    chk(tag, {31'd0, fsr_valid}, {31'd0, mvalid});
    if (mvalid) chk(tag, {26'd0, fsr_code, fsr_dom}, {26'd0, mcode, mdom});
    if (mvalid) chk(tag, far_addr, mfar);
  endtask

  function automatic logic [31:0] fill(logic [1:0] m);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) r[2*i +: 2] = m;
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {30'd0, exc_req, fsr_valid}, 32'd0);
    @(negedge clk); rst_n = 1;
    // R1: reset register refuses everything
    cyc(0, 0, 0, 1, 2'b00, 1, 32'h1000_0000, 4'd5, 2'b11, 0);
    cyc(0, 0, 1, 0, 2'b00, 0, 0, 0, 0, 0);
    // Sweep all mode settings (including reserved) over domain/priv/kind/ap/xn
    for (int m = 0; m < 4; m++) begin
      cyc(1, fill(m[1:0]), 1, 0, 0, 0, 0, 0, 0, 0);
      for (int d = 0; d < 16; d++)
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 3; k++)
            for (int a = 0; a < 4; a++)
              for (int x = 0; x < 2; x++)
                cyc(0, 0, (a == 3 && x == 1), 1, k[1:0], p[0], {d[3:0], 28'h0} | 32'(a * 16 + x),
                    d[3:0], a[1:0], x[0]);
    end
    // R2: write with concurrent access uses old value; per-field placement
    cyc(1, fill(2'b11), 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h0000_0000, 1, 1, 2'b01, 0, 32'hA, 4'd3, 2'b00, 0);
    cyc(0, 0, 0, 1, 2'b01, 0, 32'hB, 4'd3, 2'b00, 0);
    cyc(1, 32'hC000_0003, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 2'b00, 0, 32'hC, 4'd15, 2'b00, 0);
    cyc(0, 0, 0, 1, 2'b00, 0, 32'hD, 4'd0, 2'b00, 1);
    cyc(0, 0, 0, 1, 2'b10, 0, 32'hE, 4'd1, 2'b11, 0);
    // R10: clear and fault in the same cycle captures the new fault
    cyc(0, 0, 1, 1, 2'b00, 0, 32'hDEAD_0001, 4'd7, 2'b00, 0);
    cyc(0, 0, 0, 1, 2'b00, 0, 32'hDEAD_0002, 4'd8, 2'b00, 0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      cyc(r[4:0] == 0, $urandom, r[9:6] == 0, r[10] | r[11], r[13:12], r[14], $urandom,
          r[19:16], r[21:20], r[22]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule